// File: doc/BRIEF.md
# Length-Counted Streaming DMA with Validation Gate

This block is a single-channel engine that moves a firmware image of a programmed byte length out of memory. Each word it fetches is offered on a valid/ready stream toward a consumer such as a hash unit. The same word is written to a destination address in the cycle the stream accepts it. Software programs three registers: a source address, a destination address and a length in bytes. It then writes a run command and polls a byte counter until that counter equals the length.

A reset command aborts any transfer in flight and is acknowledged through a sticky status bit. The protocol expects that reset before the next run whenever the run bit is still set from an earlier transfer. Once the move is finished, software writes a run-enable request to a qualifier register. That request only reads back as set when two things hold at the moment of the write: the whole message has moved, and an external validator input signals approval. The hash algorithm and the validator are outside the block.

Registers sit at word indices on `regAddr`. Index 0 is the command register: bit 0 is run, bit 1 is reset, and reads show run in bit 0 with bit 1 always 0. Index 1 is status, with the reset-done flag in bit 1. Index 2 is the source address, index 3 the destination address and index 4 the length in bytes. Index 5 is the byte count and is read-only. Index 6 is the qualifier, using bit 0. Any other index reads as zero.

Top module: `hashFeedDma`

## Requirements
- R1: After reset every register reads zero, `outValid` and `rdEn` are low.
- R2: After a run command, beat k carries the source word at byte address source+4k and is written to destination+4k with the same data; `wrEn` is high exactly in the cycles where `outValid` and `outReady` are both high.
- R3: The byte count (index 5) grows by the number of bytes in each accepted beat and stops at the programmed length; after completion no more beats are produced.
- R4: A beat is the last one when at most 4 bytes remain. It carries `outLast`=1, and `outStrb`/`wrStrb` have their low n bits set for n remaining bytes: 1 gives 0001, 2 gives 0011, 3 gives 0111 and 4 gives 1111. Every earlier beat has strobe 1111 and `outLast`=0.
- R5: While `outValid` is high and `outReady` is low, the offered data and strobes stay unchanged, `wrEn` stays low and the count does not advance.
- R6: A run command written while a transfer is still moving data is ignored: the count is not restarted and the data sequence continues.
- R7: Writing command bit 1 aborts the transfer at once. No further beats appear, the count reads 0, command bit 0 reads 0, the qualifier reads 0 and status bit 1 reads 1. When bits 0 and 1 are written together, the reset wins.
- R8: Status bit 1 returns to 0 when the next run command is accepted.
- R9: Writing 1 to qualifier bit 0 makes it read 1 only when three conditions hold at the write: no transfer is moving, the count equals the length register, and `validatorOk` is high. Otherwise it reads 0. Writing 0 clears it.
- R10: A run with length 0 finishes immediately, produces no beats and leaves the count at 0.
- R11: Command bit 0 reads 1 from an accepted run until the next reset command, including after completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word index |
| regWdata | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational on `regAddr`) |
| validatorOk | input | 1 | External image validation passed |
| rdEn | output | 1 | Source read request |
| rdAddr | output | 32 | Source byte address |
| rdValid | input | 1 | Source read data valid |
| rdData | input | 32 | Source read data |
| outValid | output | 1 | Stream beat valid |
| outReady | input | 1 | Stream consumer ready |
| outData | output | 32 | Stream beat data |
| outStrb | output | 4 | Stream byte enables |
| outLast | output | 1 | Final beat of the message |
| wrEn | output | 1 | Destination write strobe |
| wrAddr | output | 32 | Destination byte address |
| wrData | output | 32 | Destination write data |
| wrStrb | output | 4 | Destination byte enables |

## Verification
The assertions assume that source and destination addresses are word aligned. They also assume that the memory returns exactly one `rdValid` pulse per `rdEn`, at any latency, and none unrequested. The bench's memory model answers each request once, alternating between zero and one extra cycle of latency. It computes each word from its address, and every programmed address is a multiple of four. Software is expected to issue a reset before each new run, and the stimulus does so. The only violation it applies on purpose is a run issued mid-transfer, which the design must ignore.

// File: rtl/hashFeedPkg.sv
package hashFeedPkg;

  localparam int REG_DW = 32;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] REG_CMD  = 3'd0;
  localparam logic [REG_AW-1:0] REG_STAT = 3'd1;
  localparam logic [REG_AW-1:0] REG_SRC  = 3'd2;
  localparam logic [REG_AW-1:0] REG_DST  = 3'd3;
  localparam logic [REG_AW-1:0] REG_LEN  = 3'd4;
  localparam logic [REG_AW-1:0] REG_CNT  = 3'd5;
  localparam logic [REG_AW-1:0] REG_QUAL = 3'd6;

  // strobes from the control block to the datapath
  typedef struct packed {
    logic start;
    logic abort;
  } xferCtl_t;

endpackage

// File: rtl/hashFeedCtrl.sv
module hashFeedCtrl
  import hashFeedPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_DW-1:0] regWdata,
  output logic [REG_DW-1:0] regRdData,
  input  logic              validatorOk,
  input  logic              busy,
  input  logic [LEN_W-1:0]  byteCount,
  output xferCtl_t          ctl,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [LEN_W-1:0]  msgLen
);

  logic runBit, resetDone, qualBit;
  logic [ADDR_W-1:0] srcQ, dstQ;
  logic [LEN_W-1:0]  lenQ;
  logic cmdWr, qualWr, qualGrant;

  assign cmdWr     = regWrEn && (regAddr == REG_CMD);
  assign qualWr    = regWrEn && (regAddr == REG_QUAL);
  assign ctl.abort = cmdWr && regWdata[1];
  assign ctl.start = cmdWr && regWdata[0] && !regWdata[1] && !busy;
  assign qualGrant = regWdata[0] && !busy && (byteCount == lenQ) && validatorOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runBit    <= 1'b0;
      resetDone <= 1'b0;
      qualBit   <= 1'b0;
      srcQ      <= '0;
      dstQ      <= '0;
      lenQ      <= '0;
    end else begin
      if (ctl.abort) begin
        runBit    <= 1'b0;
        resetDone <= 1'b1;
        qualBit   <= 1'b0;
      end else if (ctl.start) begin
        runBit    <= 1'b1;
        resetDone <= 1'b0;
      end
      if (qualWr) qualBit <= qualGrant;
      if (regWrEn && regAddr == REG_SRC) srcQ <= regWdata[ADDR_W-1:0];
      if (regWrEn && regAddr == REG_DST) dstQ <= regWdata[ADDR_W-1:0];
      if (regWrEn && regAddr == REG_LEN) lenQ <= regWdata[LEN_W-1:0];
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      REG_CMD:  regRdData[0] = runBit;
      REG_STAT: regRdData[1] = resetDone;
      REG_SRC:  regRdData = REG_DW'(srcQ);
      REG_DST:  regRdData = REG_DW'(dstQ);
      REG_LEN:  regRdData = REG_DW'(lenQ);
      REG_CNT:  regRdData = REG_DW'(byteCount);
      REG_QUAL: regRdData[0] = qualBit;
      default:  regRdData = '0;
    endcase
  end

  assign srcAddr = srcQ;
  assign dstAddr = dstQ;
  assign msgLen  = lenQ;

  // R9
  qual_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(qualBit) |-> $past(validatorOk) && !$past(busy))
    else $error("qualifier set without validation");

  // R7
  reset_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.abort |=> resetDone && !runBit && !qualBit)
    else $error("reset not acknowledged");

  // R8
  run_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.start |=> runBit && !resetDone)
    else $error("run did not clear reset-done");

endmodule

// File: rtl/hashFeedPath.sv
module hashFeedPath
  import hashFeedPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 20,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  xferCtl_t            ctl,
  input  logic [ADDR_W-1:0]   srcAddr,
  input  logic [ADDR_W-1:0]   dstAddr,
  input  logic [LEN_W-1:0]    msgLen,
  output logic                rdEn,
  output logic [ADDR_W-1:0]   rdAddr,
  input  logic                rdValid,
  input  logic [DATA_W-1:0]   rdData,
  output logic                outValid,
  input  logic                outReady,
  output logic [DATA_W-1:0]   outData,
  output logic [DATA_W/8-1:0] outStrb,
  output logic                outLast,
  output logic                wrEn,
  output logic [ADDR_W-1:0]   wrAddr,
  output logic [DATA_W-1:0]   wrData,
  output logic [DATA_W/8-1:0] wrStrb,
  output logic                busy,
  output logic [LEN_W-1:0]    byteCount
);

  localparam int BYTES = DATA_W / 8;

  logic [ADDR_W-1:0] curSrc, curDst;
  logic [LEN_W-1:0]  curLen, cntQ, remaining, stepBytes;
  logic              busyQ, pendQ, bufValid, lastBeat, accept;
  logic [DATA_W-1:0] bufData;
  logic [BYTES-1:0]  beatStrb;

  assign remaining = curLen - cntQ;
  assign lastBeat  = remaining <= LEN_W'(BYTES);
  assign stepBytes = lastBeat ? remaining : LEN_W'(BYTES);
  assign accept    = bufValid && outReady;

  always_comb begin
    for (int i = 0; i < BYTES; i++) beatStrb[i] = LEN_W'(i) < remaining;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curSrc   <= '0;
      curDst   <= '0;
      curLen   <= '0;
      cntQ     <= '0;
      busyQ    <= 1'b0;
      pendQ    <= 1'b0;
      bufValid <= 1'b0;
      bufData  <= '0;
    end else if (ctl.abort) begin
      cntQ     <= '0;
      busyQ    <= 1'b0;
      pendQ    <= 1'b0;
      bufValid <= 1'b0;
    end else if (ctl.start) begin
      curSrc   <= srcAddr;
      curDst   <= dstAddr;
      curLen   <= msgLen;
      cntQ     <= '0;
      busyQ    <= msgLen != '0;
      pendQ    <= 1'b0;
      bufValid <= 1'b0;
    end else if (busyQ) begin
      if (rdEn) pendQ <= 1'b1;
      if (pendQ && rdValid) begin
        bufData  <= rdData;
        bufValid <= 1'b1;
        pendQ    <= 1'b0;
      end
      if (accept) begin
        bufValid <= 1'b0;
        cntQ     <= cntQ + stepBytes;
        if (lastBeat) busyQ <= 1'b0;
      end
    end
  end

  assign rdEn      = busyQ && !pendQ && !bufValid;
  assign rdAddr    = curSrc + ADDR_W'(cntQ);
  assign outValid  = bufValid;
  assign outData   = bufData;
  assign outStrb   = beatStrb;
  assign outLast   = lastBeat;
  assign wrEn      = accept;
  assign wrAddr    = curDst + ADDR_W'(cntQ);
  assign wrData    = bufData;
  assign wrStrb    = beatStrb;
  assign busy      = busyQ;
  assign byteCount = cntQ;

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= curLen)
    else $error("byte count beyond length");

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady && !ctl.abort |=> outValid && $stable(outData) && $stable(outStrb) && $stable(cntQ))
    else $error("held beat changed");

  // R7
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.abort |=> cntQ == '0 && !outValid && !busyQ)
    else $error("abort left state behind");

  // R3
  last_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept && lastBeat && !ctl.abort |=> !busyQ && !outValid)
    else $error("engine busy after last beat");

endmodule

// File: rtl/hashFeedDma.sv
module hashFeedDma
  import hashFeedPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 20,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic [REG_DW-1:0]   regWdata,
  output logic [REG_DW-1:0]   regRdData,
  input  logic                validatorOk,
  output logic                rdEn,
  output logic [ADDR_W-1:0]   rdAddr,
  input  logic                rdValid,
  input  logic [DATA_W-1:0]   rdData,
  output logic                outValid,
  input  logic                outReady,
  output logic [DATA_W-1:0]   outData,
  output logic [DATA_W/8-1:0] outStrb,
  output logic                outLast,
  output logic                wrEn,
  output logic [ADDR_W-1:0]   wrAddr,
  output logic [DATA_W-1:0]   wrData,
  output logic [DATA_W/8-1:0] wrStrb
);

  xferCtl_t          ctl;
  logic              busy;
  logic [LEN_W-1:0]  byteCount, msgLen;
  logic [ADDR_W-1:0] srcAddr, dstAddr;

  hashFeedCtrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdData(regRdData), .validatorOk(validatorOk),
    .busy(busy), .byteCount(byteCount), .ctl(ctl),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .msgLen(msgLen)
  );

  hashFeedPath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) path_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .srcAddr(srcAddr), .dstAddr(dstAddr),
    .msgLen(msgLen), .rdEn(rdEn), .rdAddr(rdAddr), .rdValid(rdValid),
    .rdData(rdData), .outValid(outValid), .outReady(outReady),
    .outData(outData), .outStrb(outStrb), .outLast(outLast), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .wrStrb(wrStrb), .busy(busy),
    .byteCount(byteCount)
  );

endmodule

// File: tb/hashFeedDma_tb_top.sv
module hashFeedDma_tb_top;
  import hashFeedPkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, regWrEn, validatorOk, rdEn, rdValid, outValid, outReady, outLast, wrEn;
  logic [2:0]  regAddr;
  logic [31:0] regWdata, regRdData, rdAddr, rdData, outData, wrAddr, wrData;
  logic [3:0]  outStrb, wrStrb;

  hashFeedDma dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdData(regRdData), .validatorOk(validatorOk),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdValid(rdValid), .rdData(rdData),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .outStrb(outStrb), .outLast(outLast), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .wrStrb(wrStrb)
  );

  int nTests = 0, nFail = 0;
  bit finished = 0;

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] dst;
    logic [19:0] len;
    logic [3:0]  mask;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{32'h1000, 32'h8000, 20'd16, 4'hF},
    '{32'h2000, 32'h9000, 20'd13, 4'b1010},
    '{32'h3000, 32'hA000, 20'd6,  4'b0110},
    '{32'h4000, 32'hB000, 20'd3,  4'hF},
    '{32'h5000, 32'hC000, 20'd1,  4'b0011},
    '{32'h6000, 32'hD000, 20'd40, 4'b1101}
  };

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // source memory model: one answer per request, latency alternates
  bit latTog = 0;
  initial begin
    rdValid = 1'b0;
    rdData  = '0;
    forever begin
      @(negedge clk);
      if (rdEn) begin
        logic [31:0] a;
        a = rdAddr;
        @(posedge clk);
        if (latTog) @(posedge clk);
        latTog = !latTog;
        #1 rdValid = 1'b1;
        rdData = memWord(a);
        @(posedge clk);
        #1 rdValid = 1'b0;
      end
    end
  end

  // stream consumer readiness pattern
  logic [3:0] readyMask = 4'hF;
  int cyc = 0;
  initial outReady = 1'b0;
  always @(posedge clk) begin
    #2 outReady = readyMask[cyc % 4];
    cyc++;
  end

  // beat monitor
  logic [31:0] expSrc = 0, expDst = 0, prevData = 0, eD;
  int expLen = 0, beatIdx = 0, rem;
  bit prevHold = 0, skipNext = 0, eLast, ok;
  logic [3:0] eStrb;
  always @(negedge clk) begin
    #2;
    if (rstN) begin
      if (prevHold && !skipNext)
        chk(outValid && outData == prevData && !(wrEn && !outReady), "R5 held beat", outData, prevData);
      if (outValid && outReady) begin
        rem   = expLen - 4 * beatIdx;
        eD    = memWord(expSrc + 32'(4 * beatIdx));
        eStrb = (rem >= 4) ? 4'hF : 4'((1 << rem) - 1);
        eLast = rem <= 4;
        ok = rem > 0 && outData == eD && wrEn && wrData == eD
             && wrAddr == expDst + 32'(4 * beatIdx);
        chk(ok, "R2 beat data/address", outData, eD);
        chk(outStrb == eStrb && wrStrb == eStrb && outLast == eLast, "R4 strobe/last",
            {27'd0, outLast, outStrb}, {27'd0, eLast, eStrb});
        beatIdx++;
      end else if (wrEn) begin
        chk(1'b0, "R2 write without accept", 32'd1, 32'd0);
      end
      prevHold = outValid && !outReady;
      prevData = outData;
      skipNext = regWrEn && regAddr == REG_CMD && regWdata[1];
    end
  end

  task automatic wrReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b0; regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic progXfer(input logic [31:0] s, input logic [31:0] d, input int len);
    wrReg(REG_SRC, s);
    wrReg(REG_DST, d);
    wrReg(REG_LEN, 32'(len));
    expSrc = s; expDst = d; expLen = len; beatIdx = 0;
  endtask

  task automatic waitCnt(input int target);
    logic [31:0] v;
    for (int k = 0; k < 3000; k++) begin
      rdReg(REG_CNT, v);
      if (int'(v) >= target) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog R3 actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c1;
    rstN = 1'b0; regWrEn = 1'b0; regAddr = '0; regWdata = '0; validatorOk = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    for (int r = 0; r < 7; r++) begin
      rdReg(3'(r), v);
      chk(v == 0, "R1 register after reset", v, 0);
    end
    chk(!outValid && !rdEn, "R1 idle outputs", {30'd0, outValid, rdEn}, 0);

    // table-driven transfers
    for (int n = 0; n < NV; n++) begin
      readyMask = VECS[n].mask;
      progXfer(VECS[n].src, VECS[n].dst, int'(VECS[n].len));
      wrReg(REG_CMD, 32'h1);
      if (n > 0) begin
        rdReg(REG_STAT, v);
        chk(v[1] == 1'b0, "R8 reset-done cleared by run", v, 0);
      end
      waitCnt(int'(VECS[n].len));
      repeat (6) @(negedge clk);
      rdReg(REG_CNT, v);
      chk(v == 32'(VECS[n].len), "R3 final count", v, 32'(VECS[n].len));
      chk(beatIdx == (int'(VECS[n].len) + 3) / 4, "R3 beat total", 32'(beatIdx), 32'((int'(VECS[n].len) + 3) / 4));
      rdReg(REG_CMD, v);
      chk(v == 1, "R11 run stays set", v, 1);
      validatorOk = 1'b1;
      wrReg(REG_QUAL, 32'h1);
      rdReg(REG_QUAL, v);
      chk(v == 1, "R9 qualifier granted", v, 1);
      validatorOk = 1'b0;
      wrReg(REG_CMD, 32'h2);
      rdReg(REG_STAT, v);
      chk(v == 2, "R7 reset-done set", v, 2);
      rdReg(REG_CMD, v);
      chk(v == 0, "R7 run cleared", v, 0);
      rdReg(REG_CNT, v);
      chk(v == 0, "R7 count cleared", v, 0);
      rdReg(REG_QUAL, v);
      chk(v == 0, "R7 qualifier cleared", v, 0);
    end

    // R6 run during an active transfer
    readyMask = 4'hF;
    progXfer(32'h7000, 32'hE000, 64);
    wrReg(REG_CMD, 32'h1);
    waitCnt(8);
    readyMask = 4'h0;
    repeat (4) @(negedge clk);
    rdReg(REG_CNT, c1);
    wrReg(REG_CMD, 32'h1);
    rdReg(REG_CNT, v);
    chk(v == c1 && c1 != 0 && c1 != 64, "R6 count kept on repeated run", v, c1);
    // R9 qualifier refused while moving
    validatorOk = 1'b1;
    wrReg(REG_QUAL, 32'h1);
    rdReg(REG_QUAL, v);
    chk(v == 0, "R9 qualifier during transfer", v, 0);
    validatorOk = 1'b0;
    readyMask = 4'hF;
    waitCnt(64);
    repeat (6) @(negedge clk);
    chk(beatIdx == 16, "R6 beat sequence continued", 32'(beatIdx), 16);
    // R9 validator low
    wrReg(REG_QUAL, 32'h1);
    rdReg(REG_QUAL, v);
    chk(v == 0, "R9 validator low", v, 0);
    validatorOk = 1'b1;
    wrReg(REG_QUAL, 32'h1);
    rdReg(REG_QUAL, v);
    chk(v == 1, "R9 validator high", v, 1);
    wrReg(REG_QUAL, 32'h0);
    rdReg(REG_QUAL, v);
    chk(v == 0, "R9 write zero clears", v, 0);
    validatorOk = 1'b0;
    wrReg(REG_CMD, 32'h2);

    // R7 abort mid transfer
    readyMask = 4'b0001;
    progXfer(32'h7800, 32'hF000, 100);
    wrReg(REG_CMD, 32'h1);
    waitCnt(8);
    wrReg(REG_CMD, 32'h2);
    c1 = 32'(beatIdx);
    rdReg(REG_CNT, v);
    chk(v == 0, "R7 abort count", v, 0);
    rdReg(REG_CMD, v);
    chk(v == 0, "R7 abort run bit", v, 0);
    rdReg(REG_STAT, v);
    chk(v == 2, "R7 abort status", v, 2);
    repeat (10) begin
      @(negedge clk);
      chk(!outValid && !rdEn, "R7 quiet after abort", {30'd0, outValid, rdEn}, 0);
    end
    chk(32'(beatIdx) == c1, "R7 no beats after abort", 32'(beatIdx), c1);
    validatorOk = 1'b1;
    wrReg(REG_QUAL, 32'h1);
    rdReg(REG_QUAL, v);
    chk(v == 0, "R9 count short of length", v, 0);
    validatorOk = 1'b0;

    // R10 zero length
    readyMask = 4'hF;
    progXfer(32'h1100, 32'h9100, 0);
    wrReg(REG_CMD, 32'h1);
    repeat (8) @(negedge clk);
    rdReg(REG_CNT, v);
    chk(v == 0, "R10 zero-length count", v, 0);
    chk(beatIdx == 0, "R10 no beats", 32'(beatIdx), 0);
    rdReg(REG_STAT, v);
    chk(v == 0, "R8 status cleared by run", v, 0);

    // R7 reset and run written together
    wrReg(REG_CMD, 32'h3);
    rdReg(REG_CMD, v);
    chk(v == 0, "R7 reset wins over run", v, 0);
    rdReg(REG_STAT, v);
    chk(v == 2, "R7 combined write acknowledged", v, 2);
    repeat (5) @(negedge clk);
    chk(!outValid && !rdEn, "R7 combined write idle", {30'd0, outValid, rdEn}, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule